// File: doc/BRIEF.md
# UART receiver status flag unit

This block keeps the receive-side status of an asynchronous serial receiver and presents it to a CPU through a small register read/write port. A receive shifter outside this block reports each finished character with a one-cycle strobe. The strobe comes with the character, the sampled stop-bit level and a parity pass/fail indication. The block stores the character and keeps four sticky flags: receive-full, overrun, framing error and parity error. It drives two interrupt lines, each gated by enable bits in a control register.

Software clears the flags in two steps. First it reads the status register. Then it reads the data register. Only the flags that the status read returned as 1 are cleared by the data read that follows. A flag that appears between the two reads, or in the same cycle as the status read, stays set until a fresh read pair completes. When a new character arrives while receive-full is still pending, the held character is kept, the new one is dropped and overrun is raised.

Top module: `uart_rx_status`

## Requirements
- R1: Synchronous active-high reset clears all four flags, the enable register, both interrupt outputs and `rd_data_o`.
- R2: The register address is `addr_i`: 0 is status, 1 is data, 2 is interrupt enable and 3 reads as zero. `rd_data_o` holds the read result in the cycle after `rd_en_i` is sampled.
- R3: When `byte_done_i` is sampled with receive-full clear, the character is stored and status bit 0 (receive-full) is set. A data read returns the stored character.
- R4: Status bit 2 (framing error) sets when `byte_done_i` is sampled with `stop_bit_i` low.
- R5: Status bit 3 (parity error) sets when `byte_done_i` is sampled with `parity_ok_i` low.
- R6: When `byte_done_i` is sampled while receive-full is set and is not being cleared in that cycle, status bit 1 (overrun) sets and the data register keeps the earlier character.
- R7: A data read clears exactly those flags that the most recent status read returned as 1. A data read with no status read before it since the last data read clears nothing.
- R8: A flag that sets after the status read, or in the same cycle as it, is not cleared by the following data read.
- R9: `err_irq_o` is the OR of overrun, framing and parity, each ANDed with the enable bit at the same position (1, 2, 3). `rx_irq_o` is receive-full ANDed with enable bit 0. Both change on the same clock edge as the flags.
- R10: Writes to addresses 0 and 1 change no flag and no stored data. A write to address 2 loads the four enable bits from `wr_data_i[3:0]`.
- R11: When a data read that clears receive-full coincides with `byte_done_i`, the new character is accepted without overrun. The read still returns the earlier character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_done_i | input | 1 | One-cycle strobe: a character has been shifted in |
| byte_i | input | DW | Received character |
| stop_bit_i | input | 1 | Sampled stop-bit level |
| parity_ok_i | input | 1 | 1 when the parity check passed |
| rd_en_i | input | 1 | Register read request |
| wr_en_i | input | 1 | Register write request |
| addr_i | input | 2 | Register address |
| wr_data_i | input | DW | Write data |
| rd_data_o | output | DW | Registered read data |
| err_irq_o | output | 1 | Error interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |

## Verification
A strobe or read issued in one cycle shows up after exactly one clock edge. The flags, the held character and both interrupt outputs change on the edge that samples `byte_done_i`. `rd_data_o` carries the value the registers had before that edge. The bench drives every input on the falling edge and holds it for a single rising edge. It samples one falling edge later, so every result it compares is exactly one edge old. The cases where a read and a new character meet in the same cycle are driven by hand so that they land on the same edge.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  localparam int FLAG_N   = 4;
  localparam int FLAG_RXF = 0;
  localparam int FLAG_OVR = 1;
  localparam int FLAG_FE  = 2;
  localparam int FLAG_PE  = 3;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rxsf_flag_cell.sv
module rxsf_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  output logic flag_d_o,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, armed_q, armed_d;

  // a set wins over a clear landing on the same edge
  always_comb begin
    flag_d_o = flag_q;
    if (set_i)                    flag_d_o = 1'b1;
    else if (data_rd_i && armed_q) flag_d_o = 1'b0;
    armed_d = armed_q;
    if (data_rd_i)      armed_d = 1'b0;
    else if (stat_rd_i) armed_d = flag_q;   // only what the read returned
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d_o;
      armed_q <= armed_d;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/rxsf_data_hold.sv
module rxsf_data_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] held_o
);
  always_ff @(posedge clk) begin
    if (rst)         held_o <= '0;
    else if (load_i) held_o <= byte_i;
  end
endmodule

// File: rtl/rxsf_irq_gen.sv
module rxsf_irq_gen
  import uart_rx_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_N-1:0] flag_d_i,
  input  logic [FLAG_N-1:0] en_d_i,
  output logic              err_irq_o,
  output logic              rx_irq_o
);
  logic [FLAG_N-1:0] gated;
  assign gated = flag_d_i & en_d_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_irq_o <= 1'b0;
      rx_irq_o  <= 1'b0;
    end else begin
      err_irq_o <= gated[FLAG_OVR] | gated[FLAG_FE] | gated[FLAG_PE];
      rx_irq_o  <= gated[FLAG_RXF];
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_done_i,
  input  logic [DW-1:0] byte_i,
  input  logic          stop_bit_i,
  input  logic          parity_ok_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          err_irq_o,
  output logic          rx_irq_o
);
  localparam int PAD = DW - FLAG_N;

  logic              stat_rd, data_rd, ctrl_wr, accept;
  logic [FLAG_N-1:0] set_vec, flag_d, flag_q, armed_q, en_q, en_d;
  logic [DW-1:0]     held_q;

  assign stat_rd = rd_en_i && (addr_i == REG_STAT);
  assign data_rd = rd_en_i && (addr_i == REG_DATA);
  assign ctrl_wr = wr_en_i && (addr_i == REG_CTRL);

  // a byte is taken when nothing is pending or the pending one is being cleared now
  assign accept = byte_done_i && (!flag_q[FLAG_RXF] || (data_rd && armed_q[FLAG_RXF]));

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_RXF] = accept;
    set_vec[FLAG_OVR] = byte_done_i && !accept;
    set_vec[FLAG_FE]  = byte_done_i && !stop_bit_i;
    set_vec[FLAG_PE]  = byte_done_i && !parity_ok_i;
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    rxsf_flag_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .set_i     (set_vec[g]),
      .stat_rd_i (stat_rd),
      .data_rd_i (data_rd),
      .flag_d_o  (flag_d[g]),
      .flag_o    (flag_q[g]),
      .armed_o   (armed_q[g])
    );
  end

  rxsf_data_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .byte_i (byte_i),
    .held_o (held_q)
  );

  assign en_d = ctrl_wr ? wr_data_i[FLAG_N-1:0] : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end

  rxsf_irq_gen u_irq (
    .clk       (clk),
    .rst       (rst),
    .flag_d_i  (flag_d),
    .en_d_i    (en_d),
    .err_irq_o (err_irq_o),
    .rx_irq_o  (rx_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else if (rd_en_i) begin
      unique case (addr_i)
        REG_STAT: rd_data_o <= {{PAD{1'b0}}, flag_q};
        REG_DATA: rd_data_o <= held_q;
        REG_CTRL: rd_data_o <= {{PAD{1'b0}}, en_q};
        default:  rd_data_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          byte_done_i,
  input logic          stop_bit_i,
  input logic          parity_ok_i,
  input logic          rd_en_i,
  input logic          wr_en_i,
  input logic [1:0]    addr_i,
  input logic [3:0]    flag_q,
  input logic [3:0]    en_q,
  input logic [DW-1:0] held_q,
  input logic          err_irq_o,
  input logic          rx_irq_o
);
  logic data_rd;
  assign data_rd = rd_en_i && (addr_i == 2'd1);

  // R3
  rxf_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    byte_done_i |=> flag_q[0]);

  // R4
  fe_on_low_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done_i && !stop_bit_i) |=> flag_q[2]);

  // R5
  pe_on_bad_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done_i && !parity_ok_i) |=> flag_q[3]);

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done_i && flag_q[0] && !data_rd) |=> (flag_q[1] && $stable(held_q)));

  // R7
  no_clear_without_data_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !data_rd |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    (err_irq_o == |(flag_q[3:1] & en_q[3:1])) && (rx_irq_o == (flag_q[0] & en_q[0])));

  // R10
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i != 2'd2 && !rd_en_i && !byte_done_i) |=> ($stable(flag_q) && $stable(held_q)));
endmodule

bind uart_rx_status uart_rx_status_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .byte_done_i(byte_done_i), .stop_bit_i(stop_bit_i),
  .parity_ok_i(parity_ok_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .flag_q(flag_q), .en_q(en_q), .held_q(held_q), .err_irq_o(err_irq_o), .rx_irq_o(rx_irq_o)
);

// File: tb/uart_rx_status_tb_top.sv
module uart_rx_status_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_done = 1'b0, stop_bit = 1'b1, parity_ok = 1'b1;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [DW-1:0] byte_in = '0, wr_data = '0;
  logic [DW-1:0] rd_data;
  logic err_irq, rx_irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_rx_status #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .byte_done_i(byte_done), .byte_i(byte_in),
    .stop_bit_i(stop_bit), .parity_ok_i(parity_ok), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .err_irq_o(err_irq), .rx_irq_o(rx_irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks enter and leave on a falling edge
  task automatic send(input logic [DW-1:0] b, input logic sb, input logic pok);
    byte_done = 1'b1; byte_in = b; stop_bit = sb; parity_ok = pok;
    @(negedge clk);
    byte_done = 1'b0; stop_bit = 1'b1; parity_ok = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] v);
    wr_en = 1'b1; addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", {6'd0, err_irq, rx_irq}, 8'd0);
    check("R1 rd_data after reset", rd_data, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    rd(2'd0, v); check("R1 status after reset", v, 8'd0);
    rd(2'd2, v); check("R1 enables after reset", v, 8'd0);
    rd(2'd3, v); check("R2 unused address", v, 8'd0);

    // sweep of stop/parity levels against every enable pattern
    for (int sb = 0; sb < 2; sb++) begin
      for (int pk = 0; pk < 2; pk++) begin
        for (int en = 0; en < 16; en++) begin
          logic [DW-1:0] b;
          logic [3:0] e;
          logic fe, pe;
          e = en[3:0]; fe = (sb == 0); pe = (pk == 0);
          b = 8'(en * 13 + sb * 64 + pk * 32 + 7);
          wr(2'd2, {4'd0, e});
          rd(2'd2, v); check("R10 enable write", v, {4'd0, e});
          send(b, sb[0], pk[0]);
          check("R9 err_irq", {7'd0, err_irq}, {7'd0, (fe & e[2]) | (pe & e[3])});
          check("R9 rx_irq", {7'd0, rx_irq}, {7'd0, e[0]});
          rd(2'd0, v); check("R3 R4 R5 status", v, {4'd0, pe, fe, 1'b0, 1'b1});
          rd(2'd1, v); check("R3 data", v, b);
          rd(2'd0, v); check("R7 cleared", v, 8'd0);
          check("R9 irq cleared", {6'd0, err_irq, rx_irq}, 8'd0);
        end
      end
    end
    wr(2'd2, 8'h0F);

    // R7: a data read with no status read clears nothing
    send(8'hA1, 1'b1, 1'b1);
    rd(2'd1, v); check("R7 data", v, 8'hA1);
    rd(2'd0, v); check("R7 unarmed data read kept rxf", v, 8'h01);
    rd(2'd1, v);
    rd(2'd0, v); check("R7 pair clears", v, 8'h00);

    // R6 and R8: overrun between the two reads survives
    send(8'hB1, 1'b1, 1'b1);
    rd(2'd0, v); check("R8 first status", v, 8'h01);
    send(8'hB2, 1'b1, 1'b1);
    check("R6 err_irq on overrun", {7'd0, err_irq}, 8'd1);
    rd(2'd1, v); check("R6 held earlier byte", v, 8'hB1);
    rd(2'd0, v); check("R8 overrun survives", v, 8'h02);
    rd(2'd1, v);
    rd(2'd0, v); check("R7 overrun cleared", v, 8'h00);

    // R6: delayed pair, overrun seen then cleared together
    send(8'hC1, 1'b1, 1'b1);
    rd(2'd0, v);
    send(8'hC2, 1'b1, 1'b1);
    rd(2'd0, v); check("R6 status with overrun", v, 8'h03);
    rd(2'd1, v); check("R6 data kept", v, 8'hC1);
    rd(2'd0, v); check("R7 both cleared", v, 8'h00);
    send(8'hC3, 1'b1, 1'b1);
    rd(2'd0, v); rd(2'd1, v); check("R3 next byte taken", v, 8'hC3);

    // R10: writes to status and data have no effect
    send(8'hD1, 1'b0, 1'b0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h55);
    rd(2'd0, v); check("R10 status write ignored", v, 8'h0D);
    rd(2'd1, v); check("R10 data write ignored", v, 8'hD1);
    rd(2'd0, v); check("R10 cleared by pair", v, 8'h00);

    // R8: status read in the same cycle as a new byte
    rd_en = 1'b1; addr = 2'd0; byte_done = 1'b1; byte_in = 8'hE1;
    @(negedge clk);
    rd_en = 1'b0; byte_done = 1'b0;
    check("R8 same-cycle status returns old", rd_data, 8'h00);
    rd(2'd1, v); check("R8 same-cycle data", v, 8'hE1);
    rd(2'd0, v); check("R8 same-cycle flag not armed", v, 8'h01);

    // R11: armed data read coincides with a new byte
    rd_en = 1'b1; addr = 2'd1; byte_done = 1'b1; byte_in = 8'hE2;
    @(negedge clk);
    rd_en = 1'b0; byte_done = 1'b0;
    check("R11 read returns earlier byte", rd_data, 8'hE1);
    rd(2'd0, v); check("R11 no overrun", v, 8'h01);
    rd(2'd1, v); check("R11 new byte held", v, 8'hE2);
    rd(2'd0, v); check("R11 cleared", v, 8'h00);

    // R1: reset after flags set
    send(8'hF1, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq after second reset", {6'd0, err_irq, rx_irq}, 8'd0);
    rd(2'd0, v); check("R1 flags after second reset", v, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule